// File: doc/BRIEF.md
# Byte-Exchange Serial Port (SPI Master/Slave)

This block is an 8-bit serial peripheral port for a small controller. It either drives the serial clock as bus master or follows an external clock as slave. A transfer is full duplex. The local shift register and the remote one form one ring, so after eight clocks each side holds the byte the other side sent. Software reaches the block through three byte-wide registers: control, status and data.

In master mode, a write to the data register is enough to start the transfer. An internal divider produces SCK, and it stops by itself after eight bits. The shift path has one transmit buffer and two receive buffers. A finished byte is copied to a receive holding register, which is overwritten if software has not read it before the next byte completes. The block also drives per-pin "force to input" outputs, which the surrounding port logic uses to override pin directions in each mode.

Top module: `spi_port`

## Requirements
- R1: Data goes out most-significant bit first in SPI mode 0. SCK idles low. MOSI (master) or MISO (slave) is stable at each rising SCK edge and changes only after a falling edge.
- R2: A transfer is full duplex. After it ends, reading the data register (address 2) returns the byte received from the peer. The peer receives the byte that was loaded.
- R3: In master mode (control bit 6 enable = 1, bit 5 master = 1), a data-register write starts SCK. After exactly 8 rising edges SCK stops low and the done flag (status bit 7, address 1) is set.
- R4: The master SCK period is the system clock divided by 4 << min(sel, 5), where sel is control bits 2:0. SCK stays high for half that period on each bit.
- R5: `irq` is high only while both the done flag and the interrupt-enable bit (control bit 7) are set.
- R6: A data-register write during a transfer is ignored: the byte in flight still goes out. The write also sets the collision bit (status bit 6).
- R7: After a status read that sees the done flag set, the next data-register access clears the done flag and the collision bit.
- R8: In slave mode (enable = 1, master = 0), the port shifts only while `ss_n_in` is low. Clock edges seen while `ss_n_in` is high leave the loaded byte and the done flag unchanged.
- R9: The data register keeps the last received byte while the next transfer shifts. An unread byte is overwritten when a later transfer completes.
- R10: Direction overrides: when enabled as master, only `miso_force_in` is high. When enabled as slave, `mosi_force_in`, `sck_force_in` and `ss_force_in` are high and `miso_force_in` is low. When disabled, all four are low.
- R11: After reset the control, status and data registers read 0, and `sck_out`, `irq` and all the override outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock when master |
| mosi_in | input | 1 | Serial data in when slave |
| mosi_out | output | 1 | Serial data out when master |
| miso_in | input | 1 | Serial data in when master |
| miso_out | output | 1 | Serial data out when slave |
| ss_n_in | input | 1 | Active-low slave select |
| mosi_force_in | output | 1 | Force MOSI pin to input |
| miso_force_in | output | 1 | Force MISO pin to input |
| sck_force_in | output | 1 | Force SCK pin to input |
| ss_force_in | output | 1 | Force select pin to input |

## Verification
The hardest case to reach is a register access that lands in the middle of a shift. The bench must write the data register while a slow master transfer is under way, and must read the holding register while a second byte is still shifting in. To get there, the bench picks the slowest divider and counts system cycles from the start write, so these accesses fall well inside the transfer. A bench model of the remote side captures MOSI at each rising edge and steps MISO after each falling edge. A second model drives SCK, MOSI and select for slave mode, with select both asserted and deasserted.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned REG_AW   = 2;
   localparam logic [1:0]  A_CTRL   = 2'd0;
   localparam logic [1:0]  A_STAT   = 2'd1;
   localparam logic [1:0]  A_DATA   = 2'd2;

   typedef struct packed {
      logic       ie;
      logic       en;
      logic       mst;
      logic [1:0] spare;
      logic [2:0] rate;
   } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned MIN_SH = 2,
   parameter int unsigned MAX_SH = 7,
   localparam int unsigned SPAN  = MAX_SH - MIN_SH,
   localparam int unsigned CW    = (MAX_SH > 1) ? MAX_SH - 1 : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   if (MIN_SH < 2 || MAX_SH < MIN_SH) begin : g_bad_range
      $error("spi_rate_gen: need 2 <= MIN_SH <= MAX_SH");
   end

   logic [CW-1:0] half_m1;
   logic [CW-1:0] cnt;

   if (SPAN == 0) begin : g_fixed
      assign half_m1 = CW'((1 << (MIN_SH - 1)) - 1);
   end else begin : g_prog
      always_comb begin
         int unsigned sh;
         sh = (int'(sel) > int'(SPAN)) ? SPAN : int'(sel);
         half_m1 = CW'((1 << (MIN_SH - 1 + sh)) - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt == half_m1) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == half_m1);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int unsigned DW = 8,
   localparam int unsigned CW = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          sample_en,
   input  logic          shift_en,
   input  logic          sin,
   output logic          sout,
   output logic [CW-1:0] cnt,
   output logic          done,
   output logic [DW-1:0] word
);
   logic [DW-1:0] sreg;
   logic          samp;

   assign word = {sreg[DW-2:0], samp};
   assign sout = sreg[DW-1];
   assign done = shift_en && !load && !clear && (cnt == CW'(DW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         samp <= 1'b0;
         cnt  <= '0;
      end else if (load) begin
         sreg <= load_val;
         cnt  <= '0;
      end else if (clear) begin
         cnt  <= '0;
      end else begin
         if (sample_en) samp <= sin;
         if (shift_en) begin
            sreg <= word;
            cnt  <= (cnt == CW'(DW - 1)) ? '0 : cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 2,
   parameter int unsigned SYNC_N   = 2,
   parameter int unsigned RATE_W   = 3,
   parameter int unsigned MIN_SH   = 2,
   parameter int unsigned MAX_SH   = 7,
   localparam int unsigned CW      = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq,
   input  logic          sck_in,
   output logic          sck_out,
   input  logic          mosi_in,
   output logic          mosi_out,
   input  logic          miso_in,
   output logic          miso_out,
   input  logic          ss_n_in,
   output logic          mosi_force_in,
   output logic          miso_force_in,
   output logic          sck_force_in,
   output logic          ss_force_in
);
   if (DW != REG_W)   begin : g_bad_dw   $error("spi_port: DW must equal the register width"); end
   if (AW != REG_AW)  begin : g_bad_aw   $error("spi_port: AW must equal the address width"); end
   if (RATE_W != 3)   begin : g_bad_rate $error("spi_port: RATE_W must match the control field"); end

   ctrl_t         ctrl_q;
   logic          ctrl_en, ctrl_mst, ctrl_ie;
   logic          flag_q, wcol_q, seen_q;
   logic [DW-1:0] rx_hold;
   logic          m_busy, sck_q;
   logic          xfer_busy, core_done;
   logic [CW-1:0] bit_cnt;
   logic [DW-1:0] core_word;
   logic          core_sout;
   logic          tick;
   logic          sck_s, ss_n_s, mosi_s, sck_d, ss_act;
   logic          wr_ctrl, wr_data, rd_stat, acc_data;
   logic          start, load, collide, clear;
   logic          samp_en, shft_en, sin;

   assign ctrl_en  = ctrl_q.en;
   assign ctrl_mst = ctrl_q.mst;
   assign ctrl_ie  = ctrl_q.ie;

   // register decode
   assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_data  = bus_wr && (bus_addr == A_DATA);
   assign rd_stat  = bus_rd && (bus_addr == A_STAT);
   assign acc_data = (bus_wr || bus_rd) && (bus_addr == A_DATA);

   // slave-side synchronisers
   spi_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_in, ss_n_in, mosi_in}),
      .q     ({sck_s, ss_n_s, mosi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign ss_act = !ss_n_s;

   // busy and start decisions
   assign xfer_busy = ctrl_en && (ctrl_mst ? m_busy : (bit_cnt != '0));
   assign load      = wr_data && ctrl_en && !xfer_busy;
   assign start     = load && ctrl_mst;
   assign collide   = wr_data && ctrl_en && xfer_busy;
   assign clear     = !ctrl_en || (!ctrl_mst && !ss_act);

   // master clock generator
   spi_rate_gen #(.SEL_W(RATE_W), .MIN_SH(MIN_SH), .MAX_SH(MAX_SH)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (m_busy && ctrl_en),
      .sel   (ctrl_q.rate),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         sck_q  <= 1'b0;
      end else if (!ctrl_en || !ctrl_mst) begin
         m_busy <= 1'b0;
         sck_q  <= 1'b0;
      end else if (start) begin
         m_busy <= 1'b1;
         sck_q  <= 1'b0;
      end else if (tick) begin
         sck_q  <= !sck_q;
         if (core_done) m_busy <= 1'b0;
      end
   end

   // edge selection per mode
   always_comb begin
      if (ctrl_mst) begin
         samp_en = tick && !sck_q;
         shft_en = tick && sck_q;
         sin     = miso_in;
      end else begin
         samp_en = ss_act && sck_s && !sck_d;
         shft_en = ss_act && !sck_s && sck_d;
         sin     = mosi_s;
      end
   end

   spi_shift_core #(.DW(DW)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .load      (load),
      .load_val  (bus_wdata),
      .sample_en (samp_en),
      .shift_en  (shft_en),
      .sin       (sin),
      .sout      (core_sout),
      .cnt       (bit_cnt),
      .done      (core_done),
      .word      (core_word)
   );

   // control, status and receive holding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flag_q  <= 1'b0;
         wcol_q  <= 1'b0;
         seen_q  <= 1'b0;
         rx_hold <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
         if (rd_stat && flag_q) seen_q <= 1'b1;
         if (acc_data && seen_q) begin
            flag_q <= 1'b0;
            wcol_q <= 1'b0;
            seen_q <= 1'b0;
         end
         if (collide)   wcol_q <= 1'b1;
         if (core_done) begin
            flag_q  <= 1'b1;
            rx_hold <= core_word;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = DW'(ctrl_q);
         A_STAT:  bus_rdata = {flag_q, wcol_q, {(DW-2){1'b0}}};
         A_DATA:  bus_rdata = rx_hold;
         default: bus_rdata = '0;
      endcase
   end

   assign irq           = ctrl_ie && flag_q;
   assign sck_out       = sck_q;
   assign mosi_out      = ctrl_mst ? core_sout : 1'b0;
   assign miso_out      = ctrl_mst ? 1'b0 : core_sout;
   assign miso_force_in = ctrl_en && ctrl_mst;
   assign mosi_force_in = ctrl_en && !ctrl_mst;
   assign sck_force_in  = ctrl_en && !ctrl_mst;
   assign ss_force_in   = ctrl_en && !ctrl_mst;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
   parameter int unsigned CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic          ctrl_en,
   input logic          ctrl_mst,
   input logic          ctrl_ie,
   input logic          m_busy,
   input logic          xfer_busy,
   input logic          core_done,
   input logic          flag_q,
   input logic          wcol_q,
   input logic          ss_act,
   input logic [CW-1:0] bit_cnt,
   input logic          sck_out,
   input logic          irq,
   input logic          miso_force_in,
   input logic          mosi_force_in
);
   a_r3_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      !m_busy |-> !sck_out);

   a_r3_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(m_busy) && ctrl_en && ctrl_mst) |-> flag_q);

   a_r6_collision_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2 && ctrl_en && xfer_busy) |=> wcol_q);

   a_r6_transfer_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2 && ctrl_en && ctrl_mst && m_busy && !core_done) |=> m_busy);

   a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q && ctrl_ie));

   a_r10_master_dirs: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && ctrl_mst) |-> (miso_force_in && !mosi_force_in));

   a_r8_deselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && !ctrl_mst && !ss_act) |=> (bit_cnt == '0));
endmodule

bind spi_port spi_port_chk #(.CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .ctrl_en       (ctrl_en),
   .ctrl_mst      (ctrl_mst),
   .ctrl_ie       (ctrl_ie),
   .m_busy        (m_busy),
   .xfer_busy     (xfer_busy),
   .core_done     (core_done),
   .flag_q        (flag_q),
   .wcol_q        (wcol_q),
   .ss_act        (ss_act),
   .bit_cnt       (bit_cnt),
   .sck_out       (sck_out),
   .irq           (irq),
   .miso_force_in (miso_force_in),
   .mosi_force_in (mosi_force_in)
);

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq, sck_out, mosi_out, miso_out;
   logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
   logic       miso_in;
   logic       mosi_force_in, miso_force_in, sck_force_in, ss_force_in;

   int n_tests = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   spi_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .mosi_in(mosi_in),
      .mosi_out(mosi_out), .miso_in(miso_in), .miso_out(miso_out),
      .ss_n_in(ss_n_in), .mosi_force_in(mosi_force_in),
      .miso_force_in(miso_force_in), .sck_force_in(sck_force_in),
      .ss_force_in(ss_force_in)
   );

   // remote slave model for master-mode transfers, sampled 1 ns after each rising clk edge
   logic [7:0] peer_sh = 8'd0;
   logic [7:0] peer_cap = 8'd0;
   int         rises = 0, high_cyc = 0, mosi_bad = 0;
   logic       sck_prev = 1'b0;
   logic       mosi_prev = 1'b0;
   assign miso_in = peer_sh[7];

   always @(posedge clk) begin
      #1;
      if (sck_out) high_cyc++;
      if (sck_out && !sck_prev) begin
         rises++;
         peer_cap = {peer_cap[6:0], mosi_out};
      end
      if (sck_out && mosi_out != mosi_prev) mosi_bad++;
      if (!sck_out && sck_prev) peer_sh = {peer_sh[6:0], 1'b0};
      sck_prev  = sck_out;
      mosi_prev = mosi_out;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic start_master(input logic [7:0] mtx, input logic [7:0] stx);
      @(negedge clk);
      peer_sh = stx; peer_cap = 8'd0; rises = 0; high_cyc = 0; mosi_bad = 0;
      wr(2'd2, mtx);
   endtask

   // remote master model for slave-mode transfers, 4 clk per SCK half period
   task automatic slave_xfer(input logic [7:0] mtx, input bit sel, output logic [7:0] cap);
      cap = 8'd0;
      @(negedge clk);
      ss_n_in = !sel; mosi_in = mtx[7];
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         cap = {cap[6:0], miso_out};
         sck_in = 1'b1;
         repeat (4) @(negedge clk);
         sck_in = 1'b0;
         mosi_in = (i < 7) ? mtx[6-i] : 1'b0;
         repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      ss_n_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic int div_of(input int sel);
      return 4 << ((sel > 5) ? 5 : sel);
   endfunction

   // {rate[2:0], master byte, slave byte}
   localparam logic [18:0] VEC [4] = '{
      {3'd0, 8'hA5, 8'h3C},
      {3'd1, 8'h01, 8'h80},
      {3'd3, 8'hFF, 8'h00},
      {3'd6, 8'h5A, 8'hC3}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v, cap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 reset state
      rd(2'd0, v); check(v == 8'h00, "R11 ctrl reset", v, 0);
      rd(2'd1, v); check(v == 8'h00, "R11 status reset", v, 0);
      rd(2'd2, v); check(v == 8'h00, "R11 data reset", v, 0);
      check({sck_out, irq, mosi_force_in, miso_force_in, sck_force_in, ss_force_in} == 6'b0,
            "R11 R10 outputs after reset",
            {sck_out, irq, mosi_force_in, miso_force_in, sck_force_in, ss_force_in}, 0);

      // vector walk: master transfers
      foreach (VEC[i]) begin
         int dv;
         dv = div_of(int'(VEC[i][18:16]));
         wr(2'd0, {3'b011, 2'b00, VEC[i][18:16]});
         if (i == 0)
            check({mosi_force_in, miso_force_in, sck_force_in, ss_force_in} == 4'b0100,
                  "R10 master overrides", {mosi_force_in, miso_force_in, sck_force_in, ss_force_in}, 4'b0100);
         start_master(VEC[i][15:8], VEC[i][7:0]);
         repeat (8 * dv + 6) @(negedge clk);
         check(peer_cap == VEC[i][15:8], "R1 MSB-first byte at peer", peer_cap, VEC[i][15:8]);
         check(mosi_bad == 0, "R1 MOSI stable while SCK high", mosi_bad, 0);
         check(rises == 8 && sck_out == 1'b0, "R3 eight rising edges then idle", rises, 8);
         check(high_cyc == 4 * dv, "R4 SCK high cycles", high_cyc, 4 * dv);
         rd(2'd1, v); check(v == 8'h80, "R3 done flag set", v, 8'h80);
         rd(2'd2, v); check(v == VEC[i][7:0], "R2 received byte", v, VEC[i][7:0]);
         rd(2'd1, v); check(v == 8'h00, "R7 flag cleared", v, 0);
      end

      // R6 collision on slowest rate
      wr(2'd0, 8'h65);
      start_master(8'h81, 8'h00);
      repeat (40) @(negedge clk);
      wr(2'd2, 8'h7E);
      rd(2'd1, v); check(v == 8'h40, "R6 collision bit during transfer", v, 8'h40);
      repeat (8 * 128 + 6) @(negedge clk);
      check(peer_cap == 8'h81, "R6 ignored write leaves byte in flight", peer_cap, 8'h81);
      rd(2'd1, v); check(v == 8'hC0, "R6 flag and collision", v, 8'hC0);
      rd(2'd2, v);
      rd(2'd1, v); check(v == 8'h00, "R7 collision cleared", v, 0);

      // R9 holding register during a later transfer, then overwrite
      wr(2'd0, 8'h60);
      start_master(8'h21, 8'h66);
      repeat (40) @(negedge clk);
      start_master(8'h12, 8'h34);
      repeat (10) @(negedge clk);
      rd(2'd2, v); check(v == 8'h66, "R9 previous byte held mid transfer", v, 8'h66);
      repeat (40) @(negedge clk);
      rd(2'd2, v); check(v == 8'h34, "R9 unread byte overwritten", v, 8'h34);
      rd(2'd1, v); check(v == 8'h80, "R7 data read without status read keeps flag", v, 8'h80);

      // R5 interrupt
      wr(2'd0, 8'hE0);
      check(irq == 1'b1, "R5 irq with flag and enable", irq, 1);
      wr(2'd0, 8'h60);
      check(irq == 1'b0, "R5 irq masked", irq, 0);
      rd(2'd1, v); rd(2'd2, v);
      wr(2'd0, 8'hE0);
      check(irq == 1'b0, "R5 irq low after clear", irq, 0);

      // slave mode
      wr(2'd0, 8'h40);
      check({mosi_force_in, miso_force_in, sck_force_in, ss_force_in} == 4'b1011,
            "R10 slave overrides", {mosi_force_in, miso_force_in, sck_force_in, ss_force_in}, 4'b1011);
      wr(2'd2, 8'h3C);
      slave_xfer(8'hA5, 1'b1, cap);
      check(cap == 8'h3C, "R8 slave sends loaded byte", cap, 8'h3C);
      rd(2'd1, v); check(v == 8'h80, "R8 slave done flag", v, 8'h80);
      rd(2'd2, v); check(v == 8'hA5, "R2 slave received byte", v, 8'hA5);

      wr(2'd2, 8'h96);
      slave_xfer(8'hFF, 1'b0, cap);
      rd(2'd1, v); check(v == 8'h00, "R8 deselected clocks set no flag", v, 0);
      slave_xfer(8'h0F, 1'b1, cap);
      check(cap == 8'h96, "R8 deselected clocks keep loaded byte", cap, 8'h96);
      rd(2'd1, v); rd(2'd2, v); check(v == 8'h0F, "R2 slave byte after deselect", v, 8'h0F);

      wr(2'd2, 8'h11);
      slave_xfer(8'h5A, 1'b1, cap);
      wr(2'd2, 8'h22);
      slave_xfer(8'hC3, 1'b1, cap);
      check(cap == 8'h22, "R8 second slave byte out", cap, 8'h22);
      rd(2'd2, v); check(v == 8'hC3, "R9 slave overrun overwrites", v, 8'hC3);

      wr(2'd0, 8'h00);
      check({mosi_force_in, miso_force_in, sck_force_in, ss_force_in} == 4'b0000,
            "R10 disabled overrides", {mosi_force_in, miso_force_in, sck_force_in, ss_force_in}, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule